// File: doc/BRIEF.md
# Pin Edge Interrupt Controller

This block watches an 8-bit input port and records transitions on each pin in a pending-flag register. For each pin, a bit in a polarity register chooses whether a rising or a falling transition counts. Each flag stays set until software writes a one to its bit. A mask register decides which pending flags reach a single combined interrupt request. A flag is recorded whether or not its pin is unmasked, so the mask affects only the request output.

Software reaches the three registers over a plain byte-wide register bus made of an address, a write strobe, write data and read data. A write takes effect on the clock edge where the strobe is high. Read data is combinational from the address. Pins are asynchronous to the clock. They pass through a synchronizer of two flops, and an edge is found by comparing successive synchronized samples. The bus and the request are control signals with no handshake: a write is always accepted, and no back-pressure exists.

Top module: `pin_edge_irq`

## Requirements
- R1: After reset, the polarity, mask and flag registers all read 0x00 and `irq_o` is low.
- R2: The polarity register is at offset 0x25, the mask register at 0x26 and the flag register at 0x27. Polarity and mask read back exactly what was last written.
- R3: When a pin's polarity bit is 1, a low-to-high transition on that pin sets its flag, and a high-to-low transition does not.
- R4: When a pin's polarity bit is 0, a high-to-low transition on that pin sets its flag, and a low-to-high transition does not.
- R5: A pin transition that first appears before clock edge k sets the flag on edge k+2. The flag still reads 0 after edge k+1.
- R6: Writing 1 to a bit at the flag offset clears that flag. Writing 0 to a bit leaves that flag unchanged.
- R7: If a flag's set event and a write-1 clear of that flag fall on the same clock edge, the flag ends up set.
- R8: A flag latches even while its mask bit is 0. `irq_o` is high exactly when some flag and its mask bit are both 1. It responds in the same cycle as a register change, so setting a mask bit over a pending flag raises `irq_o` right after that write's edge.
- R9: A pin held high through reset and released sets no flag while the polarity keeps its reset value.
- R10: A write to an address other than the three offsets changes no register. A read from such an address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous port pins |
| bus_addr | input | 8 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A wrong flag state shows up at the flag read port. Because `irq_o` is combinational from the flags and mask, it also shows up on `irq_o` in the same cycle. A missed or spurious edge therefore becomes visible on the third clock edge after the pin changes. A clear that goes wrong shows up on the edge right after the write. The bench samples at exactly those edges, so an off-by-one in the synchronizer depth, a swapped polarity or an inverted clear priority gives a wrong value on the first read that follows it.

// File: rtl/pei_pkg.sv
package pei_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_POL  = 2'd1,
    SEL_MASK = 2'd2,
    SEL_FLAG = 2'd3
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(
    input logic [7:0] a,
    input logic [7:0] pol_ofs,
    input logic [7:0] mask_ofs,
    input logic [7:0] flag_ofs
  );
    if (a == pol_ofs)       return SEL_POL;
    else if (a == mask_ofs) return SEL_MASK;
    else if (a == flag_ofs) return SEL_FLAG;
    else                    return SEL_NONE;
  endfunction
endpackage

// File: rtl/pei_sync.sv
module pei_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pei_edge.sv
module pei_edge #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] hit_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= level_i;
  end

  generate
    for (genvar p = 0; p < W; p++) begin : g_pin
      assign rise[p]  = level_i[p] & ~prev_q[p];
      assign fall[p]  = ~level_i[p] & prev_q[p];
      assign hit_o[p] = pol_i[p] ? rise[p] : fall[p];
    end
  endgenerate

  // R3: a pin cannot rise on two consecutive samples
  assert_no_double_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/pei_regfile.sv
module pei_regfile
  import pei_pkg::*;
#(
  parameter int          W        = 8,
  parameter logic [7:0]  POL_OFS  = 8'h25,
  parameter logic [7:0]  MASK_OFS = 8'h26,
  parameter logic [7:0]  FLAG_OFS = 8'h27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   bus_addr,
  input  logic         bus_wr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] hit_i,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] flag_o
);
  reg_sel_e     sel;
  logic [W-1:0] pol_q, mask_q, flag_q;
  logic [W-1:0] clr_vec;

  assign sel     = decode_sel(bus_addr, POL_OFS, MASK_OFS, FLAG_OFS);
  assign clr_vec = (bus_wr && sel == SEL_FLAG) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      mask_q <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_POL)  pol_q  <= bus_wdata;
      if (sel == SEL_MASK) mask_q <= bus_wdata;
    end
  end

  generate
    for (genvar p = 0; p < W; p++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q[p] <= 1'b0;
        else if (hit_i[p])   flag_q[p] <= 1'b1;
        else if (clr_vec[p]) flag_q[p] <= 1'b0;
      end
    end
  endgenerate

  always_comb begin
    unique case (sel)
      SEL_POL:  bus_rdata = pol_q;
      SEL_MASK: bus_rdata = mask_q;
      SEL_FLAG: bus_rdata = flag_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pol_o  = pol_q;
  assign mask_o = mask_q;
  assign flag_o = flag_q;

  // R6: written ones clear flags that saw no edge
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_FLAG) |=> ((flag_q & $past(bus_wdata) & ~$past(hit_i)) == '0));

  // R6: without a write to the flag offset and without edges, flags hold
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && sel == SEL_FLAG) && hit_i == '0) |=> $stable(flag_q));

  // R7: an edge always leaves its flag set, even against a clear
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_i) |=> ((flag_q & $past(hit_i)) == $past(hit_i)));

  // R10: writes elsewhere leave polarity and mask unchanged
  assert_foreign_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel == SEL_NONE) |=> ($stable(pol_q) && $stable(mask_q)));
endmodule

// File: rtl/pin_edge_irq.sv
module pin_edge_irq #(
  parameter int         NPINS       = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] POL_OFS     = 8'h25,
  parameter logic [7:0] MASK_OFS    = 8'h26,
  parameter logic [7:0] FLAG_OFS    = 8'h27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic [7:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq_o
);
  logic [NPINS-1:0] level;
  logic [NPINS-1:0] pol;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] flag;
  logic [NPINS-1:0] hit;

  pei_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(level)
  );

  pei_edge #(.W(NPINS)) u_edge (
    .clk(clk), .rst_n(rst_n), .level_i(level), .pol_i(pol), .hit_o(hit)
  );

  pei_regfile #(
    .W(NPINS), .POL_OFS(POL_OFS), .MASK_OFS(MASK_OFS), .FLAG_OFS(FLAG_OFS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .hit_i(hit),
    .pol_o(pol), .mask_o(mask), .flag_o(flag)
  );

  assign irq_o = |(flag & mask);

  // R8: with every mask bit clear the request stays low
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_o);

  // R8: a request always points at a pending flag
  assert_irq_has_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flag != '0));
endmodule

// File: tb/sim_pin_edge_irq.sv
module sim_pin_edge_irq;
  localparam logic [7:0] A_POL  = 8'h25;
  localparam logic [7:0] A_MASK = 8'h26;
  localparam logic [7:0] A_FLAG = 8'h27;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'h00;
  logic [7:0] addr = 8'h00;
  logic       wen = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  pin_edge_irq u0 (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .bus_addr(addr),
    .bus_wr(wen), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  // fields: polarity, mask, pins, clear-after, expected flags, expected irq
  // Covers R3 (rising), R4 (falling), R6 (clear), R8 (masking)
  localparam logic [47:0] VEC [0:8] = '{
    {8'hFF, 8'h00, 8'h0F, 8'h00, 8'h0F, 8'h00},
    {8'hFF, 8'h01, 8'h0F, 8'h05, 8'h0F, 8'h01},
    {8'h00, 8'hF0, 8'h00, 8'h0F, 8'h0F, 8'h00},
    {8'h00, 8'hFF, 8'hF0, 8'h00, 8'h00, 8'h00},
    {8'h00, 8'hFF, 8'h00, 8'hF0, 8'hF0, 8'h01},
    {8'hAA, 8'hFF, 8'hFF, 8'hAA, 8'hAA, 8'h01},
    {8'hAA, 8'hFF, 8'h00, 8'h55, 8'h55, 8'h01},
    {8'h0F, 8'h80, 8'h3C, 8'h00, 8'h0C, 8'h00},
    {8'h0F, 8'h0C, 8'h3C, 8'h0C, 8'h0C, 8'h01}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    logic [7:0] v;
    pins = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    rd(A_POL, v);  chk("R1 polarity reset", v, 8'h00);
    rd(A_MASK, v); chk("R1 mask reset", v, 8'h00);
    rd(A_FLAG, v); chk("R1 flag reset", v, 8'h00);
    chk("R1 irq reset", {7'd0, irq}, 8'h00);

    settle();
    rd(A_FLAG, v); chk("R9 pin high through reset", v, 8'h00);

    wr(A_POL, 8'h5A);  rd(A_POL, v);  chk("R2 polarity readback", v, 8'h5A);
    wr(A_MASK, 8'hA5); rd(A_MASK, v); chk("R2 mask readback", v, 8'hA5);
    wr(8'h28, 8'hFF);
    rd(A_POL, v);  chk("R10 polarity after foreign write", v, 8'h5A);
    rd(A_MASK, v); chk("R10 mask after foreign write", v, 8'hA5);
    rd(A_FLAG, v); chk("R10 flag after foreign write", v, 8'h00);
    rd(8'h24, v);  chk("R10 unmapped read", v, 8'h00);

    wr(A_POL, 8'hFF);
    wr(A_MASK, 8'h00);
    @(negedge clk); pins = 8'h00;
    settle();
    rd(A_FLAG, v); chk("R3 falling ignored under rising polarity", v, 8'h00);

    for (int i = 0; i < 9; i++) begin
      logic [47:0] e;
      e = VEC[i];
      wr(A_POL, e[47:40]);
      wr(A_MASK, e[39:32]);
      @(negedge clk); pins = e[31:24];
      settle();
      rd(A_FLAG, v);
      chk($sformatf("R3/R4 vector %0d flags", i), v, e[15:8]);
      chk($sformatf("R8 vector %0d irq", i), {7'd0, irq}, e[7:0]);
      wr(A_FLAG, e[23:16]);
      rd(A_FLAG, v);
      chk($sformatf("R6 vector %0d after clear", i), v, e[15:8] & ~e[23:16]);
    end

    // R6: zeros do not clear
    wr(A_POL, 8'hFF);
    @(negedge clk); pins = 8'h3D;
    settle();
    wr(A_FLAG, 8'h00); rd(A_FLAG, v); chk("R6 zero write keeps flag", v, 8'h01);
    wr(A_FLAG, 8'hFE); rd(A_FLAG, v); chk("R6 other bits keep flag", v, 8'h01);
    wr(A_FLAG, 8'h01); rd(A_FLAG, v); chk("R6 one write clears", v, 8'h00);

    // R8: masked flag latches, unmasking raises irq at once
    wr(A_MASK, 8'h00);
    @(negedge clk); pins = 8'h3F;
    settle();
    rd(A_FLAG, v); chk("R8 flag latches while masked", v, 8'h02);
    chk("R8 irq low while masked", {7'd0, irq}, 8'h00);
    wr(A_MASK, 8'h02);
    #1;
    chk("R8 irq right after unmask", {7'd0, irq}, 8'h01);
    wr(A_FLAG, 8'h02);
    #1;
    chk("R8 irq drops after clear", {7'd0, irq}, 8'h00);

    // R5: latency of three edges
    @(negedge clk); pins = 8'h7F;
    @(posedge clk); @(posedge clk);
    rd(A_FLAG, v); chk("R5 flag not yet set after two edges", v, 8'h00);
    @(posedge clk);
    rd(A_FLAG, v); chk("R5 flag set after three edges", v, 8'h40);
    wr(A_FLAG, 8'h40);

    // R7: clear on the same edge as the set
    @(negedge clk); pins = 8'hFF;
    @(posedge clk); @(posedge clk);
    wr(A_FLAG, 8'h80);
    rd(A_FLAG, v); chk("R7 set wins over same-edge clear", v, 8'h80);
    wr(A_FLAG, 8'h80);
    @(negedge clk); pins = 8'h7F;
    settle();
    rd(A_FLAG, v); chk("R3 falling ignored before R7 contrast", v, 8'h00);
    @(negedge clk); pins = 8'hFF;
    @(posedge clk); @(posedge clk); @(posedge clk);
    wr(A_FLAG, 8'h80);
    rd(A_FLAG, v); chk("R7 clear one edge later wins", v, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule